// File: doc/BRIEF.md
# Dual-Mode Zero-Substitution Line Codec

This block is the digital coding stage of one channel of a coaxial line interface for the DS3, STS-1 and E3 rates. Its transmit half takes NRZ data, one bit per strobe, and produces positive and negative rail pulse indications. Marks alternate polarity. Runs of zeros are replaced by substitution patterns that contain a deliberate bipolar violation. In DS3/STS-1 mode the code is B3ZS, which replaces every run of three zeros. In E3 mode the code is HDB3, which replaces every run of four zeros. Its receive half takes recovered dual-rail pulses, removes valid substitutions to restore NRZ data, and flags line code violations on the bit they belong to.

A codec-disable control turns both halves into a one-clock dual-rail pass-through. Rail signals are logic-level and are qualified by a one-cycle strobe per bit, with independent strobes for transmit and receive. The mode controls are set while reset is held and stay static until the next reset. Pulse shaping, equalization, clock recovery and the analog drivers belong to other blocks.

Top module: `lc_codec`

## Requirements
- R1: The substitution window L is 3 when `mode_e3`=0 (B3ZS) and 4 when `mode_e3`=1 (HDB3). Each run of L consecutive input zeros, counted from the last mark or the last substitution, is replaced on the line.
- R2: The first position of a substitution window carries a B pulse when an even number of pulses has been sent since the last violation, and a zero otherwise. The last position carries a violation V, which has the same polarity as the pulse before it. After reset the last polarity is negative and the count is even.
- R3: Encoded marks and B pulses alternate polarity with the preceding pulse, and the encoder never raises both rails at once.
- R4: With the codec enabled, the transmit output beat for strobe k carries the line symbol of input bit k-4, and the first four beats after reset are pulse-free. Each output beat appears one clock after its strobe. All rails, the LCV flag and the valid outputs are low in cycles without a strobe.
- R5: With `codec_off`=1, each half copies its input rails to its output rails one clock after the strobe, unchanged, and `rx_lcv_o` stays low.
- R6: With the codec enabled, the transmit input takes single-rail NRZ data on `tx_pos_i`, and `tx_neg_i` has no effect on the output.
- R7: In the decoder, a pulse with the same polarity as the previous pulse is a valid substitution when the L-2 received symbols just before it carried no pulse. The pulse and the L-1 positions before it then decode to zero. NRZ data appears on `rx_pos_o` four strobes later, and `rx_neg_o` stays low.
- R8: A same-polarity pulse that does not form a valid substitution decodes as a one and raises `rx_lcv_o` on its own output beat.
- R9: The L-th consecutive pulse-free received symbol, and every further one in the same run, raises `rx_lcv_o` on its output beat.
- R10: A received symbol with both rails high raises `rx_lcv_o` and decodes as zero. It ends the current zero run, leaves the last polarity unchanged, and counts as a pulse for the substitution check.
- R11: Encoder output fed back into the decoder returns the original data delayed by eight strobes.
- R12: After reset all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_e3 | input | 1 | 1 selects HDB3, 0 selects B3ZS |
| codec_off | input | 1 | 1 bypasses encoding and decoding |
| tx_vld_i | input | 1 | Transmit bit strobe |
| tx_pos_i | input | 1 | NRZ data, or positive rail in bypass |
| tx_neg_i | input | 1 | Negative rail in bypass |
| tx_vld_o | output | 1 | Transmit output beat valid |
| tx_pos_o | output | 1 | Positive pulse indication |
| tx_neg_o | output | 1 | Negative pulse indication |
| rx_vld_i | input | 1 | Receive symbol strobe |
| rx_pos_i | input | 1 | Received positive pulse |
| rx_neg_i | input | 1 | Received negative pulse |
| rx_vld_o | output | 1 | Receive output beat valid |
| rx_pos_o | output | 1 | Decoded NRZ data, or positive rail in bypass |
| rx_neg_o | output | 1 | Negative rail in bypass, low otherwise |
| rx_lcv_o | output | 1 | Line code violation for this beat |

## Verification
The hardest case to reach is the choice between the plain and the B-pulse substitution forms when substitutions follow each other closely. Only a parity state that is invisible at the ports decides between them. The stimulus uses sparse ones, so that zero windows often come back to back or are separated by one or two marks, which drives both parity cases many times in each mode. Decoder violations are reached by feeding the encoder's own line back with occasional polarity flips and both-rail symbols, and by a phase of unstructured rail noise.

// File: rtl/lc_pkg.sv
package lc_pkg;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int WIN_MAX = 4;
  localparam int CNT_W   = $clog2(WIN_MAX + 1);

  typedef enum logic [2:0] {
    SYM_ZERO,
    SYM_MARK,
    SYM_HEAD,
    SYM_FILL,
    SYM_VIOL
  } enc_sym_t;

  typedef struct packed {
    logic data;
    logic raw;
    logic lcv;
  } dec_slot_t;

  typedef struct packed {
    logic pos;
    logic neg;
    logic last_pos;
    logic odd;
  } emit_t;

  // substitution window length for the selected code
  function automatic logic [CNT_W-1:0] win_len(input logic e3);
    return e3 ? CNT_W'(4) : CNT_W'(3);
  endfunction

  // line pulse for one queued symbol, given the last polarity and pulse parity
  function automatic emit_t emit_sym(input enc_sym_t s, input logic last_pos,
                                     input logic odd);
    emit_t e;
    e.pos      = 1'b0;
    e.neg      = 1'b0;
    e.last_pos = last_pos;
    e.odd      = odd;
    case (s)
      SYM_MARK: begin
        e.pos      = !last_pos;
        e.neg      = last_pos;
        e.last_pos = !last_pos;
        e.odd      = !odd;
      end
      SYM_HEAD: begin
        if (!odd) begin
          e.pos      = !last_pos;
          e.neg      = last_pos;
          e.last_pos = !last_pos;
          e.odd      = 1'b1;
        end
      end
      SYM_VIOL: begin
        e.pos = last_pos;
        e.neg = !last_pos;
        e.odd = 1'b0;
      end
      default: ;
    endcase
    return e;
  endfunction
endpackage

// File: rtl/lc_tx_enc.sv
module lc_tx_enc
  import lc_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mode_e3,
  input  logic codec_off,
  input  logic in_vld,
  input  logic in_pos,
  input  logic in_neg,
  output logic out_vld,
  output logic out_pos,
  output logic out_neg
);
  timeunit 1ns;
  timeprecision 1ps;

  enc_sym_t         sr_q [DEPTH];
  enc_sym_t         sr_d [DEPTH];
  logic [CNT_W-1:0] zrun_q, zrun_d;
  logic [CNT_W-1:0] win;
  logic             last_q, odd_q;
  logic             sub_fire;
  enc_sym_t         head_sym;
  emit_t            em;
  logic             step;
  // events brought out for the checks
  logic             mark_ev, viol_ev, mark_q, viol_q;

  assign win      = win_len(mode_e3);
  assign step     = in_vld && !codec_off;
  assign sub_fire = !in_pos && (zrun_q == win - CNT_W'(1));
  assign head_sym = sr_q[DEPTH-1];
  assign em       = emit_sym(head_sym, last_q, odd_q);
  assign mark_ev  = (head_sym == SYM_MARK);
  assign viol_ev  = (head_sym == SYM_VIOL);

  always_comb begin
    sr_d[0] = in_pos ? SYM_MARK : SYM_ZERO;
    for (int i = 1; i < DEPTH; i++) sr_d[i] = sr_q[i-1];
    if (sub_fire) begin
      sr_d[0] = SYM_VIOL;
      for (int i = 1; i < DEPTH; i++) begin
        if (i == int'(win) - 1)     sr_d[i] = SYM_HEAD;
        else if (i < int'(win) - 1) sr_d[i] = SYM_FILL;
      end
    end
    if (in_pos || sub_fire) zrun_d = '0;
    else                    zrun_d = zrun_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) sr_q[i] <= SYM_ZERO;
      zrun_q  <= '0;
      last_q  <= 1'b0;
      odd_q   <= 1'b0;
      out_vld <= 1'b0;
      out_pos <= 1'b0;
      out_neg <= 1'b0;
      mark_q  <= 1'b0;
      viol_q  <= 1'b0;
    end else begin
      out_vld <= in_vld;
      mark_q  <= step && mark_ev;
      viol_q  <= step && viol_ev;
      if (step) begin
        sr_q   <= sr_d;
        zrun_q <= zrun_d;
        last_q <= em.last_pos;
        odd_q  <= em.odd;
      end
      if (!in_vld) begin
        out_pos <= 1'b0;
        out_neg <= 1'b0;
      end else if (codec_off) begin
        out_pos <= in_pos;
        out_neg <= in_neg;
      end else begin
        out_pos <= em.pos;
        out_neg <= em.neg;
      end
    end
  end

  // polarity of the last pulse seen on the output rails
  logic chk_last;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                   chk_last <= 1'b0;
    else if (out_vld && (out_pos || out_neg) && (mark_q || viol_q || !codec_off))
                                                  chk_last <= out_pos;
  end

  p_viol_same_pol_r2: assert property (@(posedge clk) disable iff (!rst_n)
    viol_q |-> (out_pos ^ out_neg) && (out_pos == chk_last));
  p_mark_alternates_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mark_q |-> (out_pos ^ out_neg) && (out_pos == !chk_last));
  p_rails_exclusive_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && !codec_off) |=> !(out_pos && out_neg));
  p_idle_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !out_vld |-> !out_pos && !out_neg);
endmodule

// File: rtl/lc_rx_dec.sv
module lc_rx_dec
  import lc_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mode_e3,
  input  logic codec_off,
  input  logic in_vld,
  input  logic in_pos,
  input  logic in_neg,
  output logic out_vld,
  output logic out_pos,
  output logic out_neg,
  output logic out_lcv
);
  timeunit 1ns;
  timeprecision 1ps;

  dec_slot_t        sr_q [DEPTH];
  dec_slot_t        sr_d [DEPTH];
  dec_slot_t        ns;
  dec_slot_t        tail;
  logic [CNT_W-1:0] zrun_q, zrun_d, zrun_inc;
  logic [CNT_W-1:0] win;
  logic             last_q, last_d;
  logic             pulse, both, viol, prior_quiet, sub_ok, step;

  assign win      = win_len(mode_e3);
  assign step     = in_vld && !codec_off;
  assign pulse    = in_pos ^ in_neg;
  assign both     = in_pos & in_neg;
  assign viol     = pulse && (in_pos == last_q);
  assign sub_ok   = viol && prior_quiet;
  assign zrun_inc = (zrun_q == win) ? win : zrun_q + CNT_W'(1);
  assign tail     = sr_q[DEPTH-1];

  always_comb begin
    prior_quiet = 1'b1;
    for (int i = 0; i < DEPTH; i++)
      if (i < int'(win) - 2 && sr_q[i].raw) prior_quiet = 1'b0;
  end

  always_comb begin
    zrun_d  = zrun_q;
    last_d  = last_q;
    ns.data = 1'b0;
    ns.raw  = 1'b0;
    ns.lcv  = 1'b0;
    if (both) begin
      ns.raw = 1'b1;
      ns.lcv = 1'b1;
      zrun_d = '0;
    end else if (!pulse) begin
      zrun_d = zrun_inc;
      ns.lcv = (zrun_inc == win);
    end else begin
      zrun_d = '0;
      last_d = in_pos;
      ns.raw = 1'b1;
      if (!viol)       ns.data = 1'b1;
      else if (!sub_ok) begin
        ns.data = 1'b1;
        ns.lcv  = 1'b1;
      end
    end
    sr_d[0] = ns;
    for (int i = 1; i < DEPTH; i++) begin
      sr_d[i] = sr_q[i-1];
      if (sub_ok && i < int'(win)) sr_d[i].data = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) sr_q[i] <= '0;
      zrun_q  <= '0;
      last_q  <= 1'b0;
      out_vld <= 1'b0;
      out_pos <= 1'b0;
      out_neg <= 1'b0;
      out_lcv <= 1'b0;
    end else begin
      out_vld <= in_vld;
      if (step) begin
        sr_q   <= sr_d;
        zrun_q <= zrun_d;
        last_q <= last_d;
      end
      if (!in_vld) begin
        out_pos <= 1'b0;
        out_neg <= 1'b0;
        out_lcv <= 1'b0;
      end else if (codec_off) begin
        out_pos <= in_pos;
        out_neg <= in_neg;
        out_lcv <= 1'b0;
      end else begin
        out_pos <= tail.data;
        out_neg <= 1'b0;
        out_lcv <= tail.lcv;
      end
    end
  end

  p_bypass_no_lcv_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && codec_off) |=> !out_lcv);
  p_nrz_neg_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && !codec_off) |=> !out_neg);
  p_idle_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !out_vld |-> !out_pos && !out_neg && !out_lcv);
  p_vld_follows_r4: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld |=> out_vld);
endmodule

// File: rtl/lc_codec.sv
module lc_codec
  import lc_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mode_e3,
  input  logic codec_off,
  input  logic tx_vld_i,
  input  logic tx_pos_i,
  input  logic tx_neg_i,
  output logic tx_vld_o,
  output logic tx_pos_o,
  output logic tx_neg_o,
  input  logic rx_vld_i,
  input  logic rx_pos_i,
  input  logic rx_neg_i,
  output logic rx_vld_o,
  output logic rx_pos_o,
  output logic rx_neg_o,
  output logic rx_lcv_o
);
  timeunit 1ns;
  timeprecision 1ps;

  lc_tx_enc #(.DEPTH(DEPTH)) u_enc (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode_e3  (mode_e3),
    .codec_off(codec_off),
    .in_vld   (tx_vld_i),
    .in_pos   (tx_pos_i),
    .in_neg   (tx_neg_i),
    .out_vld  (tx_vld_o),
    .out_pos  (tx_pos_o),
    .out_neg  (tx_neg_o)
  );

  lc_rx_dec #(.DEPTH(DEPTH)) u_dec (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode_e3  (mode_e3),
    .codec_off(codec_off),
    .in_vld   (rx_vld_i),
    .in_pos   (rx_pos_i),
    .in_neg   (rx_neg_i),
    .out_vld  (rx_vld_o),
    .out_pos  (rx_pos_o),
    .out_neg  (rx_neg_o),
    .out_lcv  (rx_lcv_o)
  );
endmodule

// File: tb/test_lc_codec.sv
module test_lc_codec;
  timeunit 1ns;
  timeprecision 1ps;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_e3 = 1'b0, codec_off = 1'b0;
  logic tx_vld_i = 1'b0, tx_pos_i = 1'b0, tx_neg_i = 1'b0;
  logic rx_vld_i = 1'b0, rx_pos_i = 1'b0, rx_neg_i = 1'b0;
  logic tx_vld_o, tx_pos_o, tx_neg_o;
  logic rx_vld_o, rx_pos_o, rx_neg_o, rx_lcv_o;

  always #2.5 clk = !clk;

  lc_codec i_lc_codec (
    .clk(clk), .rst_n(rst_n), .mode_e3(mode_e3), .codec_off(codec_off),
    .tx_vld_i(tx_vld_i), .tx_pos_i(tx_pos_i), .tx_neg_i(tx_neg_i),
    .tx_vld_o(tx_vld_o), .tx_pos_o(tx_pos_o), .tx_neg_o(tx_neg_o),
    .rx_vld_i(rx_vld_i), .rx_pos_i(rx_pos_i), .rx_neg_i(rx_neg_i),
    .rx_vld_o(rx_vld_o), .rx_pos_o(rx_pos_o), .rx_neg_o(rx_neg_o),
    .rx_lcv_o(rx_lcv_o)
  );

  int checks = 0;
  int fails  = 0;
  int win;

  // encoder reference: line symbols as +1 / -1 / 0, one per input bit
  int line[$];
  int in_bits[$];
  int ez, lastv;
  // decoder reference
  int rawp[$], dd[$], dl[$];
  int dlast, dz;
  // expected outputs for the beat in flight
  logic e_tv, e_tp, e_tn, e_rv, e_rp, e_rn, e_rl, e_rt_on, e_rt;

  function automatic int last_pulse(int upto);
    for (int j = upto - 1; j >= 0; j--) if (line[j] != 0) return line[j];
    return -1;
  endfunction

  function automatic void enc_push(int b);
    int k, st, cnt, lp;
    k = line.size();
    in_bits.push_back(b);
    if (b != 0) begin
      line.push_back(-last_pulse(k));
      ez = 0;
    end else begin
      line.push_back(0);
      ez++;
      if (ez == win) begin
        ez = 0;
        st = k - win + 1;
        cnt = 0;
        for (int j = st - 1; j > lastv; j--) if (line[j] != 0) cnt++;
        lp = last_pulse(st);
        if (cnt % 2 == 0) begin
          line[st] = -lp;
          line[k]  = -lp;
        end else line[k] = lp;
        lastv = k;
      end
    end
  endfunction

  function automatic void dec_push(logic p, logic n);
    int i, pol, ok;
    i = rawp.size();
    if (p && n) begin
      rawp.push_back(1); dd.push_back(0); dl.push_back(1); dz = 0;
    end else if (!p && !n) begin
      dz = (dz + 1 > win) ? win : dz + 1;
      rawp.push_back(0); dd.push_back(0); dl.push_back(dz >= win ? 1 : 0);
    end else begin
      pol = p ? 1 : -1;
      dz = 0;
      if (pol == dlast) begin
        ok = 1;
        for (int j = 1; j <= win - 2; j++)
          if (i - j >= 0 && rawp[i-j] != 0) ok = 0;
        rawp.push_back(1);
        if (ok != 0) begin
          dd.push_back(0); dl.push_back(0);
          for (int j = 1; j <= win - 1; j++) if (i - j >= 0) dd[i-j] = 0;
        end else begin
          dd.push_back(1); dl.push_back(1);
        end
      end else begin
        rawp.push_back(1); dd.push_back(1); dl.push_back(0);
      end
      dlast = pol;
    end
  endfunction

  task automatic compare(string ttag, string rtag);
    checks++;
    if ({tx_vld_o, tx_pos_o, tx_neg_o} !== {e_tv, e_tp, e_tn}) begin
      fails++;
      $display("FAIL %s tx vld/pos/neg got %b%b%b exp %b%b%b", ttag,
               tx_vld_o, tx_pos_o, tx_neg_o, e_tv, e_tp, e_tn);
    end
    checks++;
    if ({rx_vld_o, rx_pos_o, rx_neg_o, rx_lcv_o} !== {e_rv, e_rp, e_rn, e_rl}) begin
      fails++;
      $display("FAIL %s rx vld/pos/neg/lcv got %b%b%b%b exp %b%b%b%b", rtag,
               rx_vld_o, rx_pos_o, rx_neg_o, rx_lcv_o, e_rv, e_rp, e_rn, e_rl);
    end
    if (e_rt_on) begin
      checks++;
      if (rx_pos_o !== e_rt) begin
        fails++;
        $display("FAIL R11 round trip data got %b exp %b", rx_pos_o, e_rt);
      end
    end
  endtask

  task automatic do_reset(logic e3, logic off);
    @(negedge clk);
    rst_n = 1'b0;
    mode_e3 = e3; codec_off = off;
    tx_vld_i = 0; tx_pos_i = 0; tx_neg_i = 0;
    rx_vld_i = 0; rx_pos_i = 0; rx_neg_i = 0;
    win = e3 ? 4 : 3;
    line.delete(); in_bits.delete(); rawp.delete(); dd.delete(); dl.delete();
    ez = 0; lastv = -1; dlast = -1; dz = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if ({tx_vld_o, tx_pos_o, tx_neg_o, rx_vld_o, rx_pos_o, rx_neg_o, rx_lcv_o} !== 7'b0) begin
      fails++;
      $display("FAIL R12 reset outputs got %b exp 0000000",
               {tx_vld_o, tx_pos_o, tx_neg_o, rx_vld_o, rx_pos_o, rx_neg_o, rx_lcv_o});
    end
  endtask

  // kind: 0 clean loopback, 1 corrupted loopback, 2 rail noise on receive
  task automatic run(logic e3, logic off, int n, int kind);
    int k, b, lv, r;
    logic rp, rn;
    string ttag, rtag;
    ttag = off ? "R5 tx bypass" : "R1 R2 R3 R4 R6 tx encode";
    rtag = off ? "R5 rx bypass" : "R7 R8 R9 R10 rx decode";
    do_reset(e3, off);
    k = 0;
    {e_tv, e_tp, e_tn, e_rv, e_rp, e_rn, e_rl, e_rt_on, e_rt} = '0;
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      if (c > 0) compare(ttag, rtag);
      {e_tv, e_tp, e_tn, e_rv, e_rp, e_rn, e_rl, e_rt_on, e_rt} = '0;
      tx_vld_i = ($urandom % 4) != 0;
      rx_vld_i = tx_vld_i;
      tx_pos_i = 0; tx_neg_i = 0; rx_pos_i = 0; rx_neg_i = 0;
      if (tx_vld_i) begin
        e_tv = 1; e_rv = 1;
        if (off) begin
          tx_pos_i = $urandom % 2; tx_neg_i = $urandom % 2;
          rx_pos_i = $urandom % 2; rx_neg_i = $urandom % 2;
          e_tp = tx_pos_i; e_tn = tx_neg_i;
          e_rp = rx_pos_i; e_rn = rx_neg_i;
        end else begin
          b = (($urandom % 10) < 3) ? 1 : 0;
          tx_pos_i = b[0];
          tx_neg_i = $urandom % 2;           // R6: must not matter
          enc_push(b);
          lv = (k >= 4) ? line[k-4] : 0;
          e_tp = (lv > 0); e_tn = (lv < 0);
          rp = (lv > 0); rn = (lv < 0);
          if (kind == 1) begin
            r = $urandom % 40;
            if (r < 2 && (rp || rn)) begin rp = !rp; rn = !rn; end
            else if (r == 2) begin rp = 1; rn = 0; end
            else if (r == 3) begin rp = 1; rn = 1; end
          end else if (kind == 2) begin
            r = $urandom % 8;
            rp = (r == 4 || r == 5 || r == 7);
            rn = (r == 6 || r == 7);
          end
          rx_pos_i = rp; rx_neg_i = rn;
          dec_push(rp, rn);
          if (k >= 4) begin e_rp = dd[k-4][0]; e_rl = dl[k-4][0]; end
          if (kind == 0) begin
            e_rt_on = 1;
            e_rt = (k >= 8) ? in_bits[k-8][0] : 1'b0;
          end
          k++;
        end
      end
    end
    @(negedge clk);
    compare(ttag, rtag);
    tx_vld_i = 0; rx_vld_i = 0;
  endtask

  initial begin
    for (int m = 0; m < 2; m++) begin
      run(m[0], 1'b0, 700, 0);
      run(m[0], 1'b0, 700, 1);
      run(m[0], 1'b0, 400, 2);
      run(m[0], 1'b1, 250, 0);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule